// File: doc/BRIEF.md
# Program Counter with Circular Return Stack

This block holds the 13-bit instruction address of a small processor core and the hardware stack of return addresses that goes with it. Each cycle the decoder presents one control code. From that code the block advances the address by one, reloads it from a written low byte, branches to an 11-bit target, or returns to a saved address. The upper address bits come from an external latch register. A full low-byte write takes all five latch bits as the high part. A call or jump takes only the top two latch bits, because the instruction supplies the other eleven.

An interrupt request takes priority over the control code. It saves the address that follows the current one and forces the fixed vector 0x004. The return stack has eight entries of 13 bits. Software cannot see its pointer, which simply wraps: pushing too often overwrites the oldest entry, and popping too often reads stale entries. Neither case raises any flag. Returning from an interrupt also gives a one-cycle pulse that tells the core to turn global interrupts back on.

Top module: `pc_stack_unit`

## Requirements
- R1: While reset is held and in the cycle after it, pc_o is 0x0000 and gie_set_o is 0.
- R2: With op_i = 0 (step), or any unused code 7, and irq_i low, pc_o becomes pc_o + 1 at the next clock edge. It wraps from 0x1FFF to 0x0000.
- R3: With op_i = 1 (low-byte write), pc_o becomes {latch_i[4:0], low_data_i[7:0]}.
- R4: With op_i = 2 (jump) or op_i = 3 (call), pc_o becomes {latch_i[4:3], tgt_i[10:0]}. A jump does not touch the stack.
- R5: A call pushes pc_o + 1. The codes op_i = 4 (return), 5 (return with literal) and 6 (return from interrupt) each pop the most recent entry and load it into pc_o.
- R6: When irq_i is high, op_i is ignored. The block pushes pc_o + 1 and loads 0x004.
- R7: gie_set_o is high for exactly the one cycle that follows a return from interrupt, and is low otherwise.
- R8: The stack holds 8 entries in a circle. After nine pushes, the ninth push has replaced the first, and the first entry can no longer be returned to.
- R9: A pop from an empty stack wraps the pointer with no error. It returns the entry in the slot just below the current pointer position. That slot is zero after reset, or holds whatever an earlier push left there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Control code from the decoder (0 step, 1 low-byte write, 2 jump, 3 call, 4 return, 5 return with literal, 6 return from interrupt) |
| irq_i | input | 1 | Interrupt request; takes priority over op_i |
| tgt_i | input | 11 | Branch target carried by a jump or call |
| low_data_i | input | 8 | Data written to the address low byte |
| latch_i | input | 5 | High-address latch register |
| pc_o | output | 13 | Current instruction address |
| gie_set_o | output | 1 | One-cycle pulse after a return from interrupt |

## Verification
The stack pointer cannot be seen from outside, so its wrap on overflow and on underflow is the hardest behaviour to observe. The stimulus issues nine calls in a row, each to a distinct target, so that every saved return address is unique. It then issues nine returns. The sequence of addresses that come back shows both the overwritten oldest entry and the pointer passing below zero. It must read P9, P8 down to P2, then P9 again. Interrupt priority is tested by raising a request in the same cycle as a call whose target must not be taken.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    typedef enum logic [2:0] {
        OP_STEP  = 3'd0,
        OP_LOWR  = 3'd1,
        OP_JUMP  = 3'd2,
        OP_CALL  = 3'd3,
        OP_RET   = 3'd4,
        OP_RETLW = 3'd5,
        OP_RETFI = 3'd6,
        OP_RSVD  = 3'd7
    } op_e;
endpackage

// File: rtl/pcs_next_addr.sv
module pcs_next_addr
    import pcs_pkg::*;
#(
    parameter int PC_W    = 13,
    parameter int LATCH_W = 5,
    parameter int TGT_W   = 11,
    parameter int DATA_W  = 8,
    parameter logic [PC_W-1:0] VEC_ADDR = 13'h004
) (
    input  logic [PC_W-1:0]    pc_q_i,
    input  logic [2:0]         op_i,
    input  logic               irq_i,
    input  logic [TGT_W-1:0]   tgt_i,
    input  logic [DATA_W-1:0]  low_data_i,
    input  logic [LATCH_W-1:0] latch_i,
    input  logic [PC_W-1:0]    stack_top_i,
    output logic [PC_W-1:0]    pc_d_o,
    output logic               push_o,
    output logic               pop_o,
    output logic [PC_W-1:0]    push_data_o,
    output logic               gie_d_o
);
    localparam int BANK_W = PC_W - TGT_W;

    op_e                op;
    logic [PC_W-1:0]    seq_addr;
    logic [PC_W-1:0]    far_addr;
    logic [PC_W-1:0]    full_addr;

    assign op        = op_e'(op_i);
    assign seq_addr  = pc_q_i + 1'b1;
    assign far_addr  = {latch_i[LATCH_W-1 -: BANK_W], tgt_i};
    assign full_addr = {latch_i, low_data_i};

    always_comb begin
        pc_d_o      = seq_addr;
        push_o      = 1'b0;
        pop_o       = 1'b0;
        push_data_o = seq_addr;
        gie_d_o     = 1'b0;
        if (irq_i) begin
            push_o = 1'b1;
            pc_d_o = VEC_ADDR;
        end else begin
            unique case (op)
                OP_LOWR:  pc_d_o = full_addr;
                OP_JUMP:  pc_d_o = far_addr;
                OP_CALL: begin
                    pc_d_o = far_addr;
                    push_o = 1'b1;
                end
                OP_RET, OP_RETLW: begin
                    pc_d_o = stack_top_i;
                    pop_o  = 1'b1;
                end
                OP_RETFI: begin
                    pc_d_o  = stack_top_i;
                    pop_o   = 1'b1;
                    gie_d_o = 1'b1;
                end
                default:  pc_d_o = seq_addr;
            endcase
        end
    end
endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
    parameter int W     = 13,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] top_o
);
    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0]          sp;
        logic [DEPTH-1:0][W-1:0]   mem;
    } stk_t;

    stk_t             stk_d, stk_q;
    logic [PTR_W-1:0] sp_below;

    assign sp_below = stk_q.sp - 1'b1;
    assign top_o    = stk_q.mem[sp_below];

    always_comb begin
        stk_d = stk_q;
        if (push_i) begin
            stk_d.mem[stk_q.sp] = wdata_i;
            stk_d.sp            = stk_q.sp + 1'b1;
        end else if (pop_i) begin
            stk_d.sp = sp_below;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    // R8
    sp_push_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> stk_q.sp == ($past(stk_q.sp) + 1'b1));

    // R9
    sp_pop_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> stk_q.sp == ($past(stk_q.sp) - 1'b1));

    // R5
    top_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> top_o == $past(wdata_i));
endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit
    import pcs_pkg::*;
#(
    parameter int PC_W    = 13,
    parameter int LATCH_W = 5,
    parameter int TGT_W   = 11,
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 8,
    parameter logic [PC_W-1:0] VEC_ADDR = 13'h004
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         op_i,
    input  logic               irq_i,
    input  logic [TGT_W-1:0]   tgt_i,
    input  logic [DATA_W-1:0]  low_data_i,
    input  logic [LATCH_W-1:0] latch_i,
    output logic [PC_W-1:0]    pc_o,
    output logic               gie_set_o
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            gie;
    } core_t;

    core_t           core_d, core_q;
    logic [PC_W-1:0] nxt_pc;
    logic [PC_W-1:0] push_data;
    logic [PC_W-1:0] stack_top;
    logic            push, pop, nxt_gie;

    pcs_next_addr #(
        .PC_W(PC_W), .LATCH_W(LATCH_W), .TGT_W(TGT_W),
        .DATA_W(DATA_W), .VEC_ADDR(VEC_ADDR)
    ) u_next (
        .pc_q_i     (core_q.pc),
        .op_i       (op_i),
        .irq_i      (irq_i),
        .tgt_i      (tgt_i),
        .low_data_i (low_data_i),
        .latch_i    (latch_i),
        .stack_top_i(stack_top),
        .pc_d_o     (nxt_pc),
        .push_o     (push),
        .pop_o      (pop),
        .push_data_o(push_data),
        .gie_d_o    (nxt_gie)
    );

    pcs_ret_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (push),
        .pop_i  (pop),
        .wdata_i(push_data),
        .top_o  (stack_top)
    );

    always_comb begin
        core_d     = core_q;
        core_d.pc  = nxt_pc;
        core_d.gie = nxt_gie;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign pc_o      = core_q.pc;
    assign gie_set_o = core_q.gie;

    // R2
    step_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_i && (op_i == 3'd0 || op_i == 3'd7)) |=> pc_o == ($past(pc_o) + 1'b1));

    // R3
    low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_i && op_i == 3'd1) |=> pc_o == {$past(latch_i), $past(low_data_i)});

    // R4
    far_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_i && (op_i == 3'd2 || op_i == 3'd3)) |=>
            (pc_o[TGT_W-1:0] == $past(tgt_i) &&
             pc_o[PC_W-1:TGT_W] == $past(latch_i[LATCH_W-1 -: PC_W-TGT_W])));

    // R6
    irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |=> pc_o == VEC_ADDR);

    // R7
    gie_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gie_set_o |-> ($past(op_i) == 3'd6 && !$past(irq_i)));

    // R5
    push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
endmodule

// File: tb/pc_stack_unit_bench.sv
`timescale 1ns/1ps
module pc_stack_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = 3'd0;
    logic        irq = 1'b0;
    logic [10:0] tgt = '0;
    logic [7:0]  dat = '0;
    logic [4:0]  lat = '0;
    logic [12:0] pc;
    logic        gie;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pc_stack_unit u_pc_stack_unit (
        .clk(clk), .rst_n(rst_n), .op_i(op), .irq_i(irq), .tgt_i(tgt),
        .low_data_i(dat), .latch_i(lat), .pc_o(pc), .gie_set_o(gie)
    );

    typedef struct packed {
        logic        irq;
        logic [2:0]  op;
        logic [10:0] tgt;
        logic [7:0]  dat;
        logic [4:0]  lat;
        logic [12:0] exp_pc;
        logic        exp_gie;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 3'd0, 11'h000, 8'h00, 5'h00, 13'h0001, 1'b0}, // R2
        '{1'b0, 3'd7, 11'h000, 8'h00, 5'h00, 13'h0002, 1'b0}, // R2 unused code
        '{1'b0, 3'd1, 11'h000, 8'h34, 5'h1A, 13'h1A34, 1'b0}, // R3
        '{1'b0, 3'd0, 11'h000, 8'h00, 5'h00, 13'h1A35, 1'b0}, // R2
        '{1'b0, 3'd2, 11'h123, 8'h00, 5'h1A, 13'h1923, 1'b0}, // R4 jump
        '{1'b0, 3'd3, 11'h055, 8'h00, 5'h08, 13'h0855, 1'b0}, // R4 call
        '{1'b0, 3'd0, 11'h000, 8'h00, 5'h00, 13'h0856, 1'b0}, // R2
        '{1'b1, 3'd0, 11'h000, 8'h00, 5'h00, 13'h0004, 1'b0}, // R6
        '{1'b0, 3'd0, 11'h000, 8'h00, 5'h00, 13'h0005, 1'b0}, // R2
        '{1'b0, 3'd6, 11'h000, 8'h00, 5'h00, 13'h0857, 1'b1}, // R5 R7
        '{1'b0, 3'd5, 11'h000, 8'h00, 5'h00, 13'h1924, 1'b0}, // R5 R7
        '{1'b0, 3'd1, 11'h000, 8'hFF, 5'h00, 13'h00FF, 1'b0}, // R3
        '{1'b0, 3'd0, 11'h000, 8'h00, 5'h00, 13'h0100, 1'b0}, // R2
        '{1'b1, 3'd3, 11'h7FF, 8'h00, 5'h1F, 13'h0004, 1'b0}, // R6 op ignored
        '{1'b0, 3'd4, 11'h000, 8'h00, 5'h00, 13'h0101, 1'b0}, // R5
        '{1'b0, 3'd1, 11'h000, 8'hFF, 5'h1F, 13'h1FFF, 1'b0}, // R3
        '{1'b0, 3'd0, 11'h000, 8'h00, 5'h00, 13'h0000, 1'b0}  // R2 wrap
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic i, input logic [2:0] o, input logic [10:0] t,
                         input logic [7:0] d, input logic [4:0] l);
        irq = i; op = o; tgt = t; dat = d; lat = l;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        finish_run();
    end

    initial begin
        @(posedge clk);
        @(negedge clk);
        chk(pc == 13'h0 && gie == 1'b0, "R1 reset", int'(pc), 0);
        rst_n = 1'b1;
        for (int k = 0; k < NV; k++) begin
            drive(TBL[k].irq, TBL[k].op, TBL[k].tgt, TBL[k].dat, TBL[k].lat);
            chk(pc == TBL[k].exp_pc, $sformatf("R2-table row %0d pc", k),
                int'(pc), int'(TBL[k].exp_pc));
            chk(gie == TBL[k].exp_gie, $sformatf("R7 table row %0d gie", k),
                int'(gie), int'(TBL[k].exp_gie));
        end

        // Reset during operation clears the address and the stack (R1)
        rst_n = 1'b0;
        #1;
        chk(pc == 13'h0 && gie == 1'b0, "R1 mid-run reset", int'(pc), 0);
        @(negedge clk);
        rst_n = 1'b1;
        chk(pc == 13'h0, "R1 after reset release", int'(pc), 0);

        // R8: nine calls; call i goes to i*16 and pushes (i-1)*16+1
        for (int i = 1; i <= 9; i++) begin
            drive(1'b0, 3'd3, 11'(i * 16), 8'h00, 5'h00);
            chk(pc == 13'(i * 16), "R4 call target", int'(pc), i * 16);
        end
        // Nine returns: P9, P8 .. P2, then P9 again (R8, R9)
        for (int k = 0; k < 8; k++) begin
            drive(1'b0, 3'd4, 11'h0, 8'h00, 5'h00);
            chk(pc == 13'((8 - k) * 16 + 1), "R8 circular pop order",
                int'(pc), (8 - k) * 16 + 1);
        end
        drive(1'b0, 3'd5, 11'h0, 8'h00, 5'h00);
        chk(pc == 13'd129, "R9 underflow wraps to newest slot", int'(pc), 129);

        // R9: after reset, an underflowing pop reads a cleared slot
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 3'd1, 11'h0, 8'h40, 5'h03);
        drive(1'b0, 3'd6, 11'h0, 8'h00, 5'h00);
        chk(pc == 13'h0, "R9 empty pop after reset", int'(pc), 0);
        chk(gie == 1'b1, "R7 pulse on interrupt return", int'(gie), 1);
        drive(1'b0, 3'd0, 11'h0, 8'h00, 5'h00);
        chk(gie == 1'b0, "R7 pulse lasts one cycle", int'(gie), 0);
        chk(pc == 13'h1, "R2 step after pop", int'(pc), 1);

        finish_run();
    end
endmodule